// File: doc/BRIEF.md
# USB Token Packet Dispatcher

This block sits behind a USB low-level line receiver. Once the receiver has collected a packet, it gives the dispatcher a one-cycle done strobe, the number of bytes it received, the packet identifier byte and the byte that follows it. The dispatcher works out what kind of packet arrived and signals the endpoint logic with a single event pulse.

Packets too short to be tokens are dropped as handshakes. DATA0 and DATA1 packets go straight to the data path, with no address check. For token packets, the dispatcher compares the address field with the programmed device address. It raises an IN event or a SETUP/OUT event, and it records the current token and the endpoint bit.

A host reply window of a few bit times leaves no room for a long pipeline. Every result therefore appears a fixed two clock cycles after the strobe. CRC checking and reply generation belong to other blocks.

Top module: `usb_tok_dispatch`

## Requirements
- R1: After reset all three event outputs are low, and the current token and endpoint bit both read zero.
- R2: A packet whose byte count is below 3 raises no event and leaves the current token and endpoint bit unchanged.
- R3: A packet of 3 or more bytes whose first byte is 0xC3 (DATA0) or 0x4B (DATA1) pulses the data event, whatever its address byte holds. The current token and endpoint bit stay unchanged.
- R4: For any other packet of 3 or more bytes, bits 6:0 of the second byte form the address. If they differ from the device address input, no event is raised and the current token is set to zero.
- R5: An address-matching token with first byte 0x69 (IN) pulses the IN event. It loads the endpoint bit from bit 7 of the second byte and leaves the current token unchanged.
- R6: An address-matching token with first byte 0x2D (SETUP) or 0xE1 (OUT) pulses the SETUP/OUT event. It loads the current token with that byte and the endpoint bit with bit 7 of the second byte.
- R7: An address-matching packet with any other first byte raises no event. It sets the current token to zero and leaves the endpoint bit unchanged.
- R8: Every event is a single-cycle pulse, and at most one event is high at a time. The event, token and endpoint results for a packet become visible exactly two rising edges after the edge that samples the done strobe.
- R9: A done strobe that arrives in the cycle after an accepted one is ignored, because the dispatcher is busy then. A strobe is taken only while the dispatcher is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_done | input | 1 | One-cycle strobe: a received packet is complete |
| pkt_len | input | LEN_W (8) | Number of bytes received, PID included |
| pkt_pid | input | 8 | First byte of the packet |
| pkt_abyte | input | 8 | Second byte: address in bits 6:0, endpoint bit in bit 7 |
| dev_addr | input | ADDR_W (7) | Programmed device address |
| ev_in | output | 1 | IN token event pulse |
| ev_setup_out | output | 1 | SETUP or OUT token event pulse |
| ev_data | output | 1 | DATA0/DATA1 packet event pulse |
| cur_tok | output | 8 | Current token register |
| ep_bit | output | 1 | Low endpoint bit of the last IN/SETUP/OUT token |

## Verification
Every result is due two rising edges after the edge that samples the strobe. The first edge captures the packet and the second registers the verdict, so the outputs are sampled on the falling edge that follows.

The bench's reference model steps on the same edges and works out the expected pulses, token and endpoint bit from the requirements alone. Outputs are compared on every falling edge, so a result that comes a cycle early, comes a cycle late, or lasts two cycles shows up as a mismatch. Back-to-back strobes check that the busy cycle drops the second packet, and the every-cycle comparison confirms that no event appears for it.

// File: rtl/usb_tok_pkg.sv
package usb_tok_pkg;

   localparam logic [7:0] PID_OUT   = 8'hE1;
   localparam logic [7:0] PID_IN    = 8'h69;
   localparam logic [7:0] PID_SETUP = 8'h2D;
   localparam logic [7:0] PID_DATA0 = 8'hC3;
   localparam logic [7:0] PID_DATA1 = 8'h4B;

   typedef enum logic [2:0] {
      CLS_NONE   = 3'd0,   // no event, no register change
      CLS_DATA   = 3'd1,   // data packet
      CLS_IN     = 3'd2,   // IN token for this device
      CLS_SETOUT = 3'd3,   // SETUP or OUT token for this device
      CLS_CLEAR  = 3'd4    // ignored token: current token cleared
   } cls_e;

   typedef struct packed {
      cls_e cls;
      logic ep;
   } verdict_t;

endpackage

// File: rtl/usb_pkt_capture.sv
module usb_pkt_capture #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_done,
   input  logic [LEN_W-1:0] pkt_len,
   input  logic [7:0]       pkt_pid,
   input  logic [7:0]       pkt_abyte,
   output logic             busy,
   output logic [LEN_W-1:0] cap_len,
   output logic [7:0]       cap_pid,
   output logic [7:0]       cap_abyte
);

   logic accept;
   assign accept = pkt_done && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         cap_len   <= '0;
         cap_pid   <= '0;
         cap_abyte <= '0;
      end else begin
         busy <= accept;
         if (accept) begin
            cap_len   <= pkt_len;
            cap_pid   <= pkt_pid;
            cap_abyte <= pkt_abyte;
         end
      end
   end

   // R9: busy lasts one cycle, so a strobe seen while busy is not taken
   p_busy_single_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

endmodule

// File: rtl/usb_pid_classify.sv
module usb_pid_classify
   import usb_tok_pkg::*;
#(
   parameter int LEN_W     = 8,
   parameter int ADDR_W    = 7,
   parameter int MIN_LEN   = 3,
   parameter bit FULL_PID  = 1'b1
) (
   input  logic [LEN_W-1:0]  len,
   input  logic [7:0]        pid,
   input  logic [7:0]        abyte,
   input  logic [ADDR_W-1:0] dev_addr,
   output verdict_t          verdict
);

   localparam int EP_POS = 7;

   logic is_in, is_out, is_setup, is_d0, is_d1;

   generate
      if (FULL_PID) begin : g_full
         assign is_in    = (pid == PID_IN);
         assign is_out   = (pid == PID_OUT);
         assign is_setup = (pid == PID_SETUP);
         assign is_d0    = (pid == PID_DATA0);
         assign is_d1    = (pid == PID_DATA1);
      end else begin : g_nibble
         assign is_in    = (pid[3:0] == PID_IN[3:0]);
         assign is_out   = (pid[3:0] == PID_OUT[3:0]);
         assign is_setup = (pid[3:0] == PID_SETUP[3:0]);
         assign is_d0    = (pid[3:0] == PID_DATA0[3:0]);
         assign is_d1    = (pid[3:0] == PID_DATA1[3:0]);
      end
   endgenerate

   logic short_pkt, addr_hit;
   assign short_pkt = (len < LEN_W'(MIN_LEN));
   assign addr_hit  = (abyte[ADDR_W-1:0] == dev_addr);

   always_comb begin
      verdict.ep  = abyte[EP_POS];
      verdict.cls = CLS_NONE;
      if (short_pkt)            verdict.cls = CLS_NONE;
      else if (is_d0 || is_d1)  verdict.cls = CLS_DATA;
      else if (!addr_hit)       verdict.cls = CLS_CLEAR;
      else if (is_in)           verdict.cls = CLS_IN;
      else if (is_setup || is_out) verdict.cls = CLS_SETOUT;
      else                      verdict.cls = CLS_CLEAR;
   end

endmodule

// File: rtl/usb_evt_reg.sv
module usb_evt_reg
   import usb_tok_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     fire,
   input  verdict_t verdict,
   input  logic [7:0] pid,
   output logic     ev_in,
   output logic     ev_setup_out,
   output logic     ev_data,
   output logic [7:0] cur_tok,
   output logic     ep_bit
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ev_in        <= 1'b0;
         ev_setup_out <= 1'b0;
         ev_data      <= 1'b0;
         cur_tok      <= '0;
         ep_bit       <= 1'b0;
      end else begin
         ev_in        <= fire && (verdict.cls == CLS_IN);
         ev_setup_out <= fire && (verdict.cls == CLS_SETOUT);
         ev_data      <= fire && (verdict.cls == CLS_DATA);
         if (fire) begin
            unique case (verdict.cls)
               CLS_IN:     ep_bit <= verdict.ep;
               CLS_SETOUT: begin
                  cur_tok <= pid;
                  ep_bit  <= verdict.ep;
               end
               CLS_CLEAR:  cur_tok <= '0;
               default:    ;
            endcase
         end
      end
   end

   // R8: at most one event at a time, each for a single cycle
   p_evt_onehot_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_in, ev_setup_out, ev_data}));
   p_evt_pulse_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_in || ev_setup_out || ev_data) |=> !(ev_in || ev_setup_out || ev_data));

endmodule

// File: rtl/usb_tok_dispatch.sv
module usb_tok_dispatch
   import usb_tok_pkg::*;
#(
   parameter int LEN_W    = 8,
   parameter int ADDR_W   = 7,
   parameter int MIN_LEN  = 3,
   parameter bit FULL_PID = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_done,
   input  logic [LEN_W-1:0]  pkt_len,
   input  logic [7:0]        pkt_pid,
   input  logic [7:0]        pkt_abyte,
   input  logic [ADDR_W-1:0] dev_addr,
   output logic              ev_in,
   output logic              ev_setup_out,
   output logic              ev_data,
   output logic [7:0]        cur_tok,
   output logic              ep_bit
);

   localparam int LEN_MAX = (1 << LEN_W) - 1;

   generate
      if (ADDR_W < 1 || ADDR_W > 7) begin : g_bad_addr
         $error("ADDR_W must leave bit 7 of the address byte for the endpoint");
      end
      if (MIN_LEN < 1 || MIN_LEN > LEN_MAX) begin : g_bad_len
         $error("MIN_LEN must be representable in LEN_W bits");
      end
   endgenerate

   logic             busy;
   logic [LEN_W-1:0] cap_len;
   logic [7:0]       cap_pid, cap_abyte;
   verdict_t         verdict;

   usb_pkt_capture #(.LEN_W(LEN_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .pkt_len(pkt_len),
      .pkt_pid(pkt_pid), .pkt_abyte(pkt_abyte), .busy(busy),
      .cap_len(cap_len), .cap_pid(cap_pid), .cap_abyte(cap_abyte)
   );

   usb_pid_classify #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .MIN_LEN(MIN_LEN),
                      .FULL_PID(FULL_PID)) u_cls (
      .len(cap_len), .pid(cap_pid), .abyte(cap_abyte),
      .dev_addr(dev_addr), .verdict(verdict)
   );

   usb_evt_reg u_evt (
      .clk(clk), .rst_n(rst_n), .fire(busy), .verdict(verdict), .pid(cap_pid),
      .ev_in(ev_in), .ev_setup_out(ev_setup_out), .ev_data(ev_data),
      .cur_tok(cur_tok), .ep_bit(ep_bit)
   );

   // R2: short packets never produce an event and keep the token
   p_short_quiet_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cap_len < LEN_W'(MIN_LEN)) |=>
         (!ev_in && !ev_setup_out && !ev_data && $stable(cur_tok)));

   // R3: data packets always reach the data path
   p_data_route_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cap_len >= LEN_W'(MIN_LEN) &&
       (cap_pid == PID_DATA0 || cap_pid == PID_DATA1)) |=> ev_data);

   // R4: a foreign address clears the token and raises nothing
   p_addr_miss_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cap_len >= LEN_W'(MIN_LEN) && cap_pid != PID_DATA0 &&
       cap_pid != PID_DATA1 && cap_abyte[ADDR_W-1:0] != dev_addr) |=>
         (cur_tok == 8'h00 && !ev_in && !ev_setup_out && !ev_data));

   // R8: an event only follows a captured packet
   p_evt_after_cap_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_in || ev_setup_out || ev_data) |-> $past(busy));

endmodule

// File: tb/usb_tok_dispatch_tb.sv
module usb_tok_dispatch_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pkt_done = 1'b0;
   logic [7:0] pkt_len = '0;
   logic [7:0] pkt_pid = '0;
   logic [7:0] pkt_abyte = '0;
   logic [6:0] dev_addr = 7'h15;
   logic       ev_in, ev_setup_out, ev_data, ep_bit;
   logic [7:0] cur_tok;

   always #5 clk = ~clk;

   usb_tok_dispatch u_dut (
      .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .pkt_len(pkt_len),
      .pkt_pid(pkt_pid), .pkt_abyte(pkt_abyte), .dev_addr(dev_addr),
      .ev_in(ev_in), .ev_setup_out(ev_setup_out), .ev_data(ev_data),
      .cur_tok(cur_tok), .ep_bit(ep_bit)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   bit    running = 1'b0;
   bit    finished = 1'b0;
   string tag = "R8";

   // behavioural reference model
   bit       m_busy = 0;
   int       m_len = 0;
   int       m_pid = 0;
   int       m_ab = 0;
   bit       m_in = 0, m_so = 0, m_dt = 0, m_ep = 0;
   int       m_tok = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_in = 0; m_so = 0; m_dt = 0; m_tok = 0; m_ep = 0;
      end else begin
         m_in = 0; m_so = 0; m_dt = 0;
         if (m_busy) begin
            m_busy = 0;
            if (m_len < 3) begin
               // R2: handshake, nothing happens
            end else if (m_pid == 'hC3 || m_pid == 'h4B) begin
               m_dt = 1;                               // R3
            end else if ((m_ab % 128) != int'(dev_addr)) begin
               m_tok = 0;                              // R4
            end else if (m_pid == 'h69) begin
               m_in = 1; m_ep = (m_ab >= 128);         // R5
            end else if (m_pid == 'h2D || m_pid == 'hE1) begin
               m_so = 1; m_tok = m_pid; m_ep = (m_ab >= 128); // R6
            end else begin
               m_tok = 0;                              // R7
            end
         end else if (pkt_done) begin
            m_busy = 1;
            m_len = int'(pkt_len); m_pid = int'(pkt_pid); m_ab = int'(pkt_abyte);
         end
      end
   end

   always @(negedge clk) begin
      if (running) begin
         n_vec++;
         if (ev_in !== m_in || ev_setup_out !== m_so || ev_data !== m_dt ||
             int'(cur_tok) != m_tok || ep_bit !== m_ep) begin
            n_bad++;
            $display("FAIL %s: got in=%b so=%b data=%b tok=%02h ep=%b, want in=%b so=%b data=%b tok=%02h ep=%b",
                     tag, ev_in, ev_setup_out, ev_data, cur_tok, ep_bit,
                     m_in, m_so, m_dt, m_tok[7:0], m_ep);
         end
      end
   end

   task automatic send(input string t, input int len, input int pid, input int ab);
      tag = t;
      @(negedge clk);
      pkt_done = 1'b1; pkt_len = len[7:0]; pkt_pid = pid[7:0]; pkt_abyte = ab[7:0];
      @(negedge clk);
      pkt_done = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: got hang, want completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values
      n_vec++;
      if (ev_in || ev_setup_out || ev_data || cur_tok != 8'h00 || ep_bit) begin
         n_bad++;
         $display("FAIL R1: got in=%b so=%b data=%b tok=%02h ep=%b, want all zero",
                  ev_in, ev_setup_out, ev_data, cur_tok, ep_bit);
      end
      running = 1'b1;

      send("R6", 3, 'h2D, 'h95);   // SETUP, ep bit 1
      send("R2", 2, 'hD2, 'h00);   // short ACK keeps token
      send("R2", 1, 'h2D, 'h15);
      send("R3", 3, 'hC3, 'h7F);   // DATA0 foreign address
      send("R3", 9, 'h4B, 'h00);   // DATA1
      send("R5", 3, 'h69, 'h15);   // IN ep 0
      send("R5", 3, 'h69, 'h95);   // IN ep 1
      send("R6", 3, 'hE1, 'h15);   // OUT ep 0
      send("R4", 3, 'h69, 'h16);   // address miss clears
      send("R6", 3, 'hE1, 'h95);
      send("R7", 3, 'hA5, 'h15);   // SOF-like PID, match, cleared
      send("R4", 3, 'h2D, 'h94);
      dev_addr = 7'h00;
      send("R5", 3, 'h69, 'h80);
      send("R6", 3, 'h2D, 'h00);
      dev_addr = 7'h7F;
      send("R6", 3, 'hE1, 'h7F);
      send("R2", 0, 'hE1, 'h7F);

      // R9: second strobe in the busy cycle is dropped
      tag = "R9";
      @(negedge clk);
      pkt_done = 1'b1; pkt_len = 8'd3; pkt_pid = 8'h69; pkt_abyte = 8'hFF;
      @(negedge clk);
      pkt_pid = 8'h2D; pkt_abyte = 8'h7F;
      @(negedge clk);
      pkt_done = 1'b0;
      repeat (4) @(negedge clk);

      tag = "R8";
      repeat (4) @(negedge clk);
      running = 1'b0;
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule